// File: doc/BRIEF.md
# Serial Byte Receiver with Mid-Bit Sampling

This block takes an asynchronous serial line and recovers 8-bit bytes from it. Each frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. All ten bits last one bit period. The bit period in clock cycles is fixed when the block is built, from a clock frequency parameter and a baud rate parameter. The line must already be synchronised to the receiver clock before it reaches `din`.

The receiver treats the first clock cycle in which the line reads low as the time origin of a frame. It then samples each bit half a period after that bit's expected start. The start bit is sampled a second time, and a frame whose start bit has gone high again is thrown away as a glitch. The receiver decides on the stop bit at its midpoint and does not wait for the stop bit to end. A good frame is reported with a one-cycle strobe while the byte sits on the output. Because the receiver is back in its idle state before the stop bit finishes, a transmitter running slightly fast can send the next start bit early and the receiver still catches it.

Top module: `serial_byte_rx`

## Requirements
- R1: The bit period P is the integer quotient CLK_HZ / BAUD, and the sampling offset H is P / 2 (integer division). When the origin is at clock edge E0, bit n (start = 0, data = 1..8, stop = 9) is sampled at edge E0 + n·P + H.
- R2: Idle state ends at any clock edge where din is 0, whether or not din was 1 one cycle earlier. That edge is the frame origin.
- R3: If din is 1 at the start bit's sample point, the frame is dropped with no strobe, and the receiver goes back to idle.
- R4: Data bits are taken least significant bit first: the first data bit sampled lands in dout bit 0, and the last one lands in dout bit 7.
- R5: If din is 0 at the stop bit's sample point, no strobe is produced and the receiver goes back to idle.
- R6: For every frame with a valid start and stop bit, dout_valid is high for exactly one clock cycle, and dout holds the received byte during that cycle.
- R7: The receiver leaves the stop state at the stop bit's sample edge. dout_valid is high in the cycle right after edge E0 + 9·P + H.
- R8: After a strobe the receiver spends exactly one cycle in a transmit state and then returns to idle whatever din is. A low din seen at the edge that ends the strobe cycle does not start a frame; the next edge does.
- R9: A synchronous active-high rst forces the idle state, clears the counters and holds dout_valid low.
- R10: Frames whose bits are 2% shorter than P, sent back to back, are all received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial line, idles high, already synchronised |
| dout_valid | output | 1 | One-cycle strobe for a received byte |
| dout | output | 8 | Received byte, meaningful while dout_valid is high |

## Verification
The bench builds the receiver with CLK_HZ = 1,600,000 and BAUD = 100,000, which gives a 16-cycle bit period and a sampling offset of 8. At that size a whole frame takes only 160 cycles, so the exact strobe cycle can be checked for every frame. Bit lengths can also be shortened by a fraction of a cycle to model a 2% fast sender. The short period also makes it cheap to line up a start bit that falls inside the strobe cycle, and a rejected stop bit that runs on into a false start.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    typedef enum logic [2:0] {
        IDLE     = 3'd0,
        START    = 3'd1,
        DATA     = 3'd2,
        STOP     = 3'd3,
        TRANSMIT = 3'd4
    } rx_state_e;

endpackage

// File: rtl/rxu_bit_timer.sv
module rxu_bit_timer #(
    parameter int PERIOD = 16,
    parameter int CNT_W  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic mid
);
    localparam int HALF = PERIOD / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (restart) begin
            t_d.cnt = CNT_W'(1);
        end else if (run) begin
            if (t_q.cnt == CNT_W'(PERIOD - 1))
                t_d.cnt = '0;
            else
                t_d.cnt = t_q.cnt + CNT_W'(1);
        end else begin
            t_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign mid = run && (t_q.cnt == CNT_W'(HALF));

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        t_q.cnt < CNT_W'(PERIOD));

    assert_cnt_cleared_R9: assert property (@(posedge clk)
        rst |=> (t_q.cnt == '0));

endmodule

// File: rtl/rxu_shifter.sv
module rxu_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] data
);
    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {bit_in, sr_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign data = sr_q;

    assert_shift_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/rxu_ctrl.sv
module rxu_ctrl
    import rxu_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int BIT_W     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic mid,
    output logic restart,
    output logic run,
    output logic shift_en,
    output logic valid
);
    typedef struct packed {
        rx_state_e        state;
        logic [BIT_W-1:0] bits;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        restart  = 1'b0;
        shift_en = 1'b0;
        unique case (c_q.state)
            IDLE: begin
                if (!din) begin
                    restart = 1'b1;
                    c_d.state = START;
                end
            end
            START: begin
                if (mid) begin
                    c_d.bits  = '0;
                    c_d.state = din ? IDLE : DATA;
                end
            end
            DATA: begin
                if (mid) begin
                    shift_en = 1'b1;
                    c_d.bits = c_q.bits + BIT_W'(1);
                    if (c_q.bits == BIT_W'(DATA_BITS - 1)) c_d.state = STOP;
                end
            end
            STOP: begin
                if (mid) c_d.state = din ? TRANSMIT : IDLE;
            end
            TRANSMIT: c_d.state = IDLE;
            default:  c_d.state = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.state <= IDLE;
            c_q.bits  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign run   = (c_q.state == START) || (c_q.state == DATA) || (c_q.state == STOP);
    assign valid = (c_q.state == TRANSMIT);

    assert_xmit_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (c_q.state == TRANSMIT) |=> (c_q.state == IDLE));

    assert_valid_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(c_q.state == STOP));

    assert_bits_range_R4: assert property (@(posedge clk) disable iff (rst)
        c_q.bits <= BIT_W'(DATA_BITS));

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (c_q.state == IDLE && !valid));

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int BAUD      = 9600,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    output logic                 dout_valid,
    output logic [DATA_BITS-1:0] dout
);
    localparam int PERIOD = CLK_HZ / BAUD;
    localparam int CNT_W  = $clog2(PERIOD + 1);
    localparam int BIT_W  = $clog2(DATA_BITS + 1);

    logic restart, run, mid, shift_en, valid;

    rxu_bit_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .run(run), .mid(mid)
    );

    rxu_ctrl #(.DATA_BITS(DATA_BITS), .BIT_W(BIT_W)) u_ctrl (
        .clk(clk), .rst(rst), .din(din), .mid(mid),
        .restart(restart), .run(run), .shift_en(shift_en), .valid(valid)
    );

    rxu_shifter #(.WIDTH(DATA_BITS)) u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(din), .data(dout)
    );

    assign dout_valid = valid;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> !dout_valid);

endmodule

// File: tb/sim_serial_byte_rx.sv
`timescale 1ns/1ps
module sim_serial_byte_rx;
    localparam int P = 16;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b1;
    logic dout_valid;
    logic [7:0] dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nstr = 0;
    logic [7:0] got_b [0:31];
    int got_c [0:31];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_byte_rx #(.CLK_HZ(1_600_000), .BAUD(100_000), .DATA_BITS(8)) u0 (
        .clk(clk), .rst(rst), .din(din), .dout_valid(dout_valid), .dout(dout)
    );

    always @(negedge clk) begin
        if (!rst && dout_valid && nstr < 32) begin
            got_b[nstr] = dout;
            got_c[nstr] = cyc;
            nstr = nstr + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pct: bit length in percent of P; stop_len > 0 overrides stop length
    task automatic send_frame(input logic [7:0] b, input logic stopv, input int pct,
                              input int stop_len, output int drop);
        logic [9:0] bits;
        bits = {stopv, b, 1'b0};
        drop = cyc;
        for (int i = 0; i < 10; i++) begin
            int len;
            len = ((i + 1) * P * pct) / 100 - (i * P * pct) / 100;
            if (i == 9 && stop_len > 0) len = stop_len;
            din = bits[i];
            wait_cyc(len);
        end
        din = 1'b1;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk("R9", "dout_valid during reset", int'(dout_valid), 0);
        rst = 1'b0;
        wait_cyc(3);
        chk("R9", "dout_valid after reset", int'(dout_valid), 0);
    endtask

    task automatic t_nominal(input logic [7:0] b);
        int base, d;
        base = nstr;
        send_frame(b, 1'b1, 100, 0, d);
        wait_cyc(20);
        chk("R6", "strobe count", nstr - base, 1);
        if (nstr > base) begin
            chk("R4", "byte value", int'(got_b[base]), int'(b));
            chk("R7", "strobe latency", got_c[base] - d, 9 * P + H + 1);
        end
    endtask

    task automatic t_glitch();
        int base, d;
        base = nstr;
        din = 1'b0;
        wait_cyc(3);
        din = 1'b1;
        wait_cyc(3 * P);
        chk("R3", "strobes after glitch", nstr - base, 0);
        send_frame(8'h3C, 1'b1, 100, 0, d);
        wait_cyc(20);
        chk("R3", "frame after glitch", nstr - base, 1);
        if (nstr > base) chk("R3", "byte after glitch", int'(got_b[base]), 8'h3C);
    endtask

    task automatic t_bad_stop();
        int base, d;
        base = nstr;
        send_frame(8'hFF, 1'b0, 100, 0, d);
        wait_cyc(4 * P);
        chk("R5", "strobes for bad stop", nstr - base, 0);
        send_frame(8'h5A, 1'b1, 100, 0, d);
        wait_cyc(20);
        chk("R5", "frame after bad stop", nstr - base, 1);
        if (nstr > base) chk("R5", "byte after bad stop", int'(got_b[base]), 8'h5A);
    endtask

    task automatic t_fast();
        int base, d0, d1, d2;
        base = nstr;
        send_frame(8'hC3, 1'b1, 98, 0, d0);
        send_frame(8'h96, 1'b1, 98, 0, d1);
        send_frame(8'h0F, 1'b1, 98, 0, d2);
        wait_cyc(20);
        chk("R10", "strobes for fast frames", nstr - base, 3);
        if (nstr >= base + 3) begin
            chk("R10", "fast byte 0", int'(got_b[base]), 8'hC3);
            chk("R10", "fast byte 1", int'(got_b[base + 1]), 8'h96);
            chk("R10", "fast byte 2", int'(got_b[base + 2]), 8'h0F);
            chk("R7", "fast byte 1 latency", got_c[base + 1] - d1, 9 * P + H + 1);
        end
    endtask

    task automatic t_early_start();
        int base, da, db;
        base = nstr;
        send_frame(8'h81, 1'b1, 100, 9 * P / 16 + 0, da);
        send_frame(8'h42, 1'b1, 100, 0, db);
        wait_cyc(20);
        chk("R2", "strobes for early start", nstr - base, 2);
        if (nstr >= base + 2) begin
            chk("R2", "first byte", int'(got_b[base]), 8'h81);
            chk("R7", "first latency", got_c[base] - da, 9 * P + H + 1);
            chk("R8", "second byte", int'(got_b[base + 1]), 8'h42);
            chk("R8", "second latency", got_c[base + 1] - db, 9 * P + H + 2);
        end
    endtask

    task automatic t_single_cycle();
        int base, d, hi;
        base = nstr;
        hi = 0;
        fork
            send_frame(8'hE7, 1'b1, 100, 0, d);
            repeat (10 * P + 10) begin
                @(negedge clk);
                if (dout_valid) hi++;
            end
        join
        chk("R6", "cycles with strobe high", hi, 1);
        chk("R1", "strobe latency", got_c[base] - d, 9 * P + H + 1);
    endtask

    task automatic t_midreset();
        int base, d;
        base = nstr;
        din = 1'b0;
        wait_cyc(P + 2);
        rst = 1'b1;
        wait_cyc(2);
        din = 1'b1;
        rst = 1'b0;
        wait_cyc(10 * P);
        chk("R9", "no strobe after reset mid-frame", nstr - base, 0);
        send_frame(8'h24, 1'b1, 100, 0, d);
        wait_cyc(20);
        chk("R9", "frame after reset", nstr - base, 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_nominal(8'hA5);
        t_nominal(8'h01);
        t_nominal(8'h80);
        t_single_cycle();
        t_glitch();
        t_bad_stop();
        t_fast();
        wait_cyc(5);
        t_early_start();
        t_midreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule